// File: doc/BRIEF.md
# Aliased partial-width register file

This block holds eight general-purpose 32-bit registers. Software-level code names each register at several widths, and the block supports those views. Every register can be accessed as a whole, or through its low 16 bits. The first four registers (indices 0 to 3) also expose two separate byte views: bits 7:0 and bits 15:8. The remaining four registers (indices 4 to 7) have no view of bits 15:8.

Two registered read ports return any legal view, zero-extended to 32 bits. A single execute/write port carries one operation per cycle. The operations are:

- copying one view into another of the same size;
- loading a constant;
- adding or subtracting a constant, or a second view, into a destination view.

A narrow result is merged into the addressed bits only. Arithmetic wraps at the chosen width and sets carry and zero flags at that width. A request that names bits 15:8 of a register that lacks that view is rejected: an error pulse is raised and nothing is changed.

Top module: `arf_regfile`

## Requirements
- R1: While `rst` is high at a clock edge, every register, both read outputs, `err`, `carry` and `zero` become 0.
- R2: A read port samples its index and size code at a clock edge and presents the selected field, zero-extended, after that edge. The size codes are: 0 for bits 7:0, 1 for bits 15:8, 2 for bits 15:0, and 3 for all 32 bits.
- R3: A read with size code 1 on register index 4 to 7 returns 0.
- R4: Operation code 0 (copy) writes the source view (`src_idx`, `wr_sz`) into the destination view (`wr_idx`, `wr_sz`). The source and destination always have the same size, so bits 15:8 go to bits 15:8.
- R5: A write with size code 0, 1 or 2 changes only the addressed bits of the destination register.
- R6: If size code 1 names register index 4 to 7, as destination or as a used source, `err` is 1 for the single cycle after the request. No register changes and no flag changes. Otherwise `err` is 0.
- R7: Operation code 1 (load) writes the low bits of `imm`, as many as the size holds, into the destination view.
- R8: Operation code 2 (add) writes the sum modulo 2^size. `carry` is set to the carry out of that width, and `zero` is set when the written field is 0.
- R9: Operation code 3 (subtract) writes destination minus operand modulo 2^size. `carry` is set when a borrow occurs, and `zero` is set when the result is 0.
- R10: Copy and load leave `carry` and `zero` unchanged.
- R11: For add and subtract, the second operand is the `imm` field when `use_imm` is 1. Otherwise it is the `src_idx` view at the same size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Execute request this cycle |
| wr_op | input | 2 | 0 copy, 1 load, 2 add, 3 subtract |
| wr_idx | input | 3 | Destination register index |
| wr_sz | input | 2 | Size code for destination and source |
| src_idx | input | 3 | Source register index |
| use_imm | input | 1 | Add/subtract takes `imm` as operand |
| imm | input | 32 | Constant operand |
| rd_a_idx | input | 3 | Read port A register index |
| rd_a_sz | input | 2 | Read port A size code |
| rd_a_data | output | 32 | Read port A data, zero-extended |
| rd_b_idx | input | 3 | Read port B register index |
| rd_b_sz | input | 2 | Read port B size code |
| rd_b_data | output | 32 | Read port B data, zero-extended |
| err | output | 1 | Illegal high-byte request pulse |
| carry | output | 1 | Carry/borrow of last add/subtract |
| zero | output | 1 | Zero result of last add/subtract |

## Verification
The bench aims at merge errors. A byte or half write that clobbers the surrounding bits shows up as a wrong full-width readback. Overflow at each width is driven: a byte add of FF+1 and a half add that spills into bit 16. A design that took carry from bit 32 would report 0 there, and one that left the result unwrapped would corrupt the upper bits. A borrow from zero and a subtract of a register from itself check the borrow and zero polarity. The bench also sends a high-byte request to the upper four registers, as destination, as source and on a read port; a design missing the check would write, leak bits 15:8, or leave `err` low.

// File: rtl/arf_pkg.sv
package arf_pkg;
  typedef enum logic [1:0] {
    SZ_LO8  = 2'd0,
    SZ_HI8  = 2'd1,
    SZ_LO16 = 2'd2,
    SZ_FULL = 2'd3
  } arf_sz_e;

  typedef enum logic [1:0] {
    OP_MOV = 2'd0,
    OP_LDI = 2'd1,
    OP_ADD = 2'd2,
    OP_SUB = 2'd3
  } arf_op_e;
endpackage

// File: rtl/arf_field_get.sv
module arf_field_get
  import arf_pkg::*;
#(
  parameter int W    = 32,
  parameter int NREG = 8,
  parameter int NHI  = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic [W-1:0]  word,
  input  logic [IW-1:0] idx,
  input  logic [1:0]    sz,
  output logic [W-1:0]  val,
  output logic          ok
);
  localparam logic [IW-1:0] HI_LIM = IW'(NHI);

  always_comb begin
    ok  = !((sz == SZ_HI8) && (idx >= HI_LIM));
    val = '0;
    case (sz)
      SZ_LO8:  val = {{(W-8){1'b0}}, word[7:0]};
      SZ_HI8:  val = ok ? {{(W-8){1'b0}}, word[15:8]} : '0;
      SZ_LO16: val = {{(W-16){1'b0}}, word[15:0]};
      default: val = word;
    endcase
  end
endmodule

// File: rtl/arf_field_put.sv
module arf_field_put
  import arf_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] word,
  input  logic [W-1:0] val,
  input  logic [1:0]   sz,
  output logic [W-1:0] merged
);
  always_comb begin
    merged = word;
    case (sz)
      SZ_LO8:  merged[7:0]  = val[7:0];
      SZ_HI8:  merged[15:8] = val[7:0];
      SZ_LO16: merged[15:0] = val[15:0];
      default: merged       = val;
    endcase
  end
endmodule

// File: rtl/arf_alu.sv
module arf_alu
  import arf_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sz,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         c,
  output logic         z
);
  localparam int PW = $clog2(W + 1);

  logic [W:0]    wide;
  logic [W-1:0]  mask;
  logic [PW-1:0] pos;

  always_comb begin
    wide = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
    case (sz)
      SZ_LO8, SZ_HI8: begin
        mask = {{(W-8){1'b0}}, 8'hFF};
        pos  = PW'(8);
      end
      SZ_LO16: begin
        mask = {{(W-16){1'b0}}, 16'hFFFF};
        pos  = PW'(16);
      end
      default: begin
        mask = '1;
        pos  = PW'(W);
      end
    endcase
    res = wide[W-1:0] & mask;
    c   = wide[pos];
    z   = (res == '0);
  end
endmodule

// File: rtl/arf_regfile.sv
module arf_regfile
  import arf_pkg::*;
#(
  parameter int NREG = 8,
  parameter int W    = 32,
  parameter int NHI  = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_op,
  input  logic [IW-1:0] wr_idx,
  input  logic [1:0]    wr_sz,
  input  logic [IW-1:0] src_idx,
  input  logic          use_imm,
  input  logic [W-1:0]  imm,
  input  logic [IW-1:0] rd_a_idx,
  input  logic [1:0]    rd_a_sz,
  output logic [W-1:0]  rd_a_data,
  input  logic [IW-1:0] rd_b_idx,
  input  logic [1:0]    rd_b_sz,
  output logic [W-1:0]  rd_b_data,
  output logic          err,
  output logic          carry,
  output logic          zero
);
  logic [NREG-1:0][W-1:0] regs_q;

  // read ports
  logic [IW-1:0] rp_idx [2];
  logic [1:0]    rp_sz  [2];
  assign rp_idx[0] = rd_a_idx;
  assign rp_idx[1] = rd_b_idx;
  assign rp_sz[0]  = rd_a_sz;
  assign rp_sz[1]  = rd_b_sz;

  for (genvar g = 0; g < 2; g++) begin : g_rd
    logic [W-1:0] fval;
    logic         fok;
    logic [W-1:0] q_r;
    arf_field_get #(.W(W), .NREG(NREG), .NHI(NHI)) u_get (
      .word(regs_q[rp_idx[g]]), .idx(rp_idx[g]), .sz(rp_sz[g]),
      .val(fval), .ok(fok)
    );
    always_ff @(posedge clk) begin
      if (rst)      q_r <= '0;
      else if (fok) q_r <= fval;
      else          q_r <= '0;
    end
  end
  assign rd_a_data = g_rd[0].q_r;
  assign rd_b_data = g_rd[1].q_r;

  // execute port operands
  logic [W-1:0] dst_val, src_val, imm_m, b_opnd, alu_res, new_val, merged;
  logic         dst_ok, src_ok, uses_src, legal, alu_c, alu_z, is_arith;

  arf_field_get #(.W(W), .NREG(NREG), .NHI(NHI)) u_dst (
    .word(regs_q[wr_idx]), .idx(wr_idx), .sz(wr_sz), .val(dst_val), .ok(dst_ok)
  );
  arf_field_get #(.W(W), .NREG(NREG), .NHI(NHI)) u_src (
    .word(regs_q[src_idx]), .idx(src_idx), .sz(wr_sz), .val(src_val), .ok(src_ok)
  );

  always_comb begin
    case (wr_sz)
      SZ_LO8, SZ_HI8: imm_m = {{(W-8){1'b0}}, imm[7:0]};
      SZ_LO16:        imm_m = {{(W-16){1'b0}}, imm[15:0]};
      default:        imm_m = imm;
    endcase
    is_arith = (wr_op == OP_ADD) || (wr_op == OP_SUB);
    uses_src = (wr_op == OP_MOV) || (is_arith && !use_imm);
    legal    = dst_ok && (!uses_src || src_ok);
    b_opnd   = uses_src ? src_val : imm_m;
  end

  arf_alu #(.W(W)) u_alu (
    .a(dst_val), .b(b_opnd), .sz(wr_sz), .sub(wr_op == OP_SUB),
    .res(alu_res), .c(alu_c), .z(alu_z)
  );

  always_comb begin
    case (wr_op)
      OP_MOV:  new_val = src_val;
      OP_LDI:  new_val = imm_m;
      default: new_val = alu_res;
    endcase
  end

  arf_field_put #(.W(W)) u_put (
    .word(regs_q[wr_idx]), .val(new_val), .sz(wr_sz), .merged(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      regs_q <= '0;
      err    <= 1'b0;
      carry  <= 1'b0;
      zero   <= 1'b0;
    end else begin
      err <= wr_en && !legal;
      if (wr_en && legal) begin
        regs_q[wr_idx] <= merged;
        if (is_arith) begin
          carry <= alu_c;
          zero  <= alu_z;
        end
      end
    end
  end
endmodule

// File: rtl/arf_checks.sv
module arf_checks #(
  parameter int NREG = 8,
  parameter int W    = 32,
  parameter int NHI  = 4,
  localparam int IW  = $clog2(NREG)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic [1:0]             wr_op,
  input logic [IW-1:0]          wr_idx,
  input logic [1:0]             wr_sz,
  input logic                   err,
  input logic                   carry,
  input logic                   zero,
  input logic [NREG-1:0][W-1:0] regs_q
);
  localparam logic [IW-1:0] HI_LIM = IW'(NHI);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (regs_q == '0 && !err && !carry && !zero)); // R1

  AST_BAD_HI_DST_ERR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sz == 2'd1 && wr_idx >= HI_LIM) |=> err); // R6

  AST_BAD_HI_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sz == 2'd1 && wr_idx >= HI_LIM) |=> $stable(regs_q)); // R6

  AST_ERR_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !err); // R6

  AST_LO8_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sz == 2'd0) |=>
      regs_q[$past(wr_idx)][W-1:8] == $past(regs_q[wr_idx][W-1:8])); // R5

  AST_HI8_KEEPS_REST: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sz == 2'd1) |=>
      (regs_q[$past(wr_idx)][7:0] == $past(regs_q[wr_idx][7:0]) &&
       regs_q[$past(wr_idx)][W-1:16] == $past(regs_q[wr_idx][W-1:16]))); // R5

  AST_MOVE_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_op == 2'd0 || wr_op == 2'd1)) |=>
      ($stable(carry) && $stable(zero))); // R10
endmodule

bind arf_regfile arf_checks #(.NREG(NREG), .W(W), .NHI(NHI)) u_checks (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_op(wr_op), .wr_idx(wr_idx),
  .wr_sz(wr_sz), .err(err), .carry(carry), .zero(zero), .regs_q(regs_q)
);

// File: tb/tb_arf_regfile.sv
module tb_arf_regfile;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, use_imm;
  logic [1:0]  wr_op, wr_sz, rd_a_sz, rd_b_sz;
  logic [2:0]  wr_idx, src_idx, rd_a_idx, rd_b_idx;
  logic [31:0] imm, rd_a_data, rd_b_data;
  logic        err, carry, zero;
  int          nchk = 0, nbad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  arf_regfile dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_op(wr_op), .wr_idx(wr_idx),
    .wr_sz(wr_sz), .src_idx(src_idx), .use_imm(use_imm), .imm(imm),
    .rd_a_idx(rd_a_idx), .rd_a_sz(rd_a_sz), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_sz(rd_b_sz), .rd_b_data(rd_b_data),
    .err(err), .carry(carry), .zero(zero)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  dst;
    logic [1:0]  sz;
    logic [2:0]  src;
    logic        ui;
    logic [31:0] imm;
    logic [2:0]  ci;
    logic [1:0]  cs;
    logic [31:0] exp;
    logic        ec;
    logic        ez;
    logic        ee;
    logic [7:0]  req;
  } vec_t;

  // op: 0 copy 1 load 2 add 3 sub; size: 0 lo8 1 hi8 2 lo16 3 full
  localparam vec_t VECS [18] = '{
    '{2'd1, 3'd0, 2'd3, 3'd0, 1'b1, 32'h12345678, 3'd0, 2'd3, 32'h12345678, 1'b0, 1'b0, 1'b0, 8'd7},  // R7
    '{2'd1, 3'd0, 2'd0, 3'd0, 1'b1, 32'h0001FF36, 3'd0, 2'd3, 32'h12345636, 1'b0, 1'b0, 1'b0, 8'd5},  // R5 R7
    '{2'd1, 3'd0, 2'd1, 3'd0, 1'b1, 32'h000000AB, 3'd0, 2'd1, 32'h000000AB, 1'b0, 1'b0, 1'b0, 8'd2},  // R2
    '{2'd0, 3'd1, 2'd3, 3'd0, 1'b0, 32'h0,        3'd1, 2'd3, 32'h1234AB36, 1'b0, 1'b0, 1'b0, 8'd4},  // R4
    '{2'd1, 3'd1, 2'd2, 3'd0, 1'b1, 32'h0000FFFF, 3'd1, 2'd3, 32'h1234FFFF, 1'b0, 1'b0, 1'b0, 8'd5},  // R5
    '{2'd2, 3'd1, 2'd0, 3'd0, 1'b1, 32'h00000001, 3'd1, 2'd3, 32'h1234FF00, 1'b1, 1'b1, 1'b0, 8'd8},  // R8
    '{2'd0, 3'd2, 2'd1, 3'd0, 1'b0, 32'h0,        3'd2, 2'd3, 32'h0000AB00, 1'b1, 1'b1, 1'b0, 8'd10}, // R10 R4
    '{2'd2, 3'd2, 2'd1, 3'd0, 1'b0, 32'h0,        3'd2, 2'd3, 32'h00005600, 1'b1, 1'b0, 1'b0, 8'd11}, // R11 R8
    '{2'd3, 3'd3, 2'd0, 3'd0, 1'b1, 32'h00000001, 3'd3, 2'd3, 32'h000000FF, 1'b1, 1'b0, 1'b0, 8'd9},  // R9
    '{2'd3, 3'd3, 2'd0, 3'd3, 1'b0, 32'h0,        3'd3, 2'd3, 32'h00000000, 1'b0, 1'b1, 1'b0, 8'd9},  // R9
    '{2'd2, 3'd4, 2'd3, 3'd0, 1'b1, 32'hFFFFFFFF, 3'd4, 2'd3, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0, 8'd8},  // R8
    '{2'd2, 3'd4, 2'd3, 3'd0, 1'b1, 32'h00000001, 3'd4, 2'd3, 32'h00000000, 1'b1, 1'b1, 1'b0, 8'd8},  // R8
    '{2'd1, 3'd5, 2'd2, 3'd0, 1'b1, 32'h00001234, 3'd5, 2'd3, 32'h00001234, 1'b1, 1'b1, 1'b0, 8'd10}, // R10
    '{2'd2, 3'd5, 2'd2, 3'd0, 1'b1, 32'h0000EDCD, 3'd5, 2'd3, 32'h00000001, 1'b1, 1'b0, 1'b0, 8'd8},  // R8
    '{2'd1, 3'd5, 2'd1, 3'd0, 1'b1, 32'h00000077, 3'd5, 2'd3, 32'h00000001, 1'b1, 1'b0, 1'b1, 8'd6},  // R6 dst
    '{2'd0, 3'd0, 2'd1, 3'd6, 1'b0, 32'h0,        3'd0, 2'd3, 32'h1234AB36, 1'b1, 1'b0, 1'b1, 8'd6},  // R6 src
    '{2'd3, 3'd6, 2'd2, 3'd5, 1'b0, 32'h0,        3'd6, 2'd3, 32'h0000FFFF, 1'b1, 1'b0, 1'b0, 8'd9},  // R9 R11
    '{2'd0, 3'd7, 2'd3, 3'd7, 1'b0, 32'h0,        3'd6, 2'd1, 32'h00000000, 1'b1, 1'b0, 1'b0, 8'd3}   // R3
  };

  task automatic check(input int req, input string what, input logic [31:0] act,
                       input logic [31:0] expv);
    nchk++;
    if (act !== expv) begin
      nbad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; wr_op = 2'd0; wr_idx = 3'd0; wr_sz = 2'd0; src_idx = 3'd0;
    use_imm = 1'b0; imm = 32'd0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL R1 watchdog expired: actual running expected finished");
    finish_run();
  end

  initial begin
    idle();
    rst = 1'b1;
    rd_a_idx = 3'd0; rd_a_sz = 2'd3; rd_b_idx = 3'd1; rd_b_sz = 2'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(1, "reset rd_a", rd_a_data, 32'h0);
    check(1, "reset rd_b", rd_b_data, 32'h0);
    check(1, "reset err", {31'd0, err}, 32'h0);
    check(1, "reset flags", {30'd0, carry, zero}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < 18; i++) begin
      wr_en = 1'b1; wr_op = VECS[i].op; wr_idx = VECS[i].dst; wr_sz = VECS[i].sz;
      src_idx = VECS[i].src; use_imm = VECS[i].ui; imm = VECS[i].imm;
      @(posedge clk);
      @(negedge clk);
      check(int'(VECS[i].req), $sformatf("vec %0d err", i), {31'd0, err}, {31'd0, VECS[i].ee});
      check(int'(VECS[i].req), $sformatf("vec %0d carry", i), {31'd0, carry}, {31'd0, VECS[i].ec});
      check(int'(VECS[i].req), $sformatf("vec %0d zero", i), {31'd0, zero}, {31'd0, VECS[i].ez});
      idle();
      rd_a_idx = VECS[i].ci; rd_a_sz = VECS[i].cs;
      @(posedge clk);
      @(negedge clk);
      check(int'(VECS[i].req), $sformatf("vec %0d data", i), rd_a_data, VECS[i].exp);
      check(6, $sformatf("vec %0d err clears", i), {31'd0, err}, 32'h0);
    end

    // R2: both ports at once, several views
    rd_a_idx = 3'd0; rd_a_sz = 2'd2; rd_b_idx = 3'd2; rd_b_sz = 2'd1;
    @(posedge clk); @(negedge clk);
    check(2, "port A lo16 r0", rd_a_data, 32'h0000AB36);
    check(2, "port B hi8 r2", rd_b_data, 32'h00000056);
    rd_a_idx = 3'd1; rd_a_sz = 2'd0; rd_b_idx = 3'd7; rd_b_sz = 2'd1;
    @(posedge clk); @(negedge clk);
    check(2, "port A lo8 r1", rd_a_data, 32'h00000000);
    check(3, "port B hi8 r7 illegal", rd_b_data, 32'h00000000);

    // R1: mid-run reset wipes contents and flags
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    rd_a_idx = 3'd0; rd_a_sz = 2'd3; rd_b_idx = 3'd6; rd_b_sz = 2'd3;
    @(posedge clk); @(negedge clk);
    check(1, "after reset r0", rd_a_data, 32'h0);
    check(1, "after reset r6", rd_b_data, 32'h0);
    check(1, "after reset flags", {30'd0, carry, zero}, 32'h0);

    finish_run();
  end
endmodule